// File: doc/BRIEF.md
# Two-Lane Interleaved Recurrence Generator

This block produces the output of a 156-word, 128-bit linear recurrence generator two words per clock. The word sequence is the same one that a single-lane generator produces one word at a time. The state is split by index parity across two storage banks of 78 words each: the even bank holds even indices and the odd bank holds odd indices. Each new word depends on three earlier words: the one just before it, the one at its own index, and the one 108 places further on, with all indices taken modulo 156. The far offset is even, so the word at its own index and the far word always sit in the same bank. Two copies of the step logic are chained, so the second lane takes the first lane's fresh result as its "previous" operand within the same cycle. No memory re-read is needed for that operand.

Software or a boot engine first fills the state through a per-bank load port. A start pulse then begins generation. From the second clock after start, every cycle presents `y0` (the earlier word) and `y1` (the next word), qualified by a single `valid`. Generation continues until reset. The new words overwrite the oldest ones in place, so the banks always hold the most recent 156 words.

Top module: `ilv_rec_gen`

## Requirements
- R1: While reset is applied, and after its release until a start is accepted, `valid` is low.
- R2: A start sampled while idle makes `valid` rise at the second rising clock edge after the sampling edge. From then on `valid` stays high on every cycle until reset.
- R3: On each valid cycle, `y0` and then `y1` are the next two words x[156+j] and x[157+j] of the single-lane sequence, with no word skipped or repeated, where x[i] for i < 156 is the loaded state.
- R4: A new word is computed as (prev AND MASK) XOR F(far) XOR P(cur). Word k of a 128-bit value is bits [32k+31:32k]. P(v) is {v0,v3,v2,v1} with the most significant word first. F(v) is {v2,v0,v3,v1} XOR v with each 64-bit half shifted left by SHIFT bits.
- R5: In the first valid cycle, `y0` is built from loaded words 155 (prev), 0 (cur) and 108 (far). `y1` is built from that `y0` (prev), word 1 (cur) and word 109 (far).
- R6: With `load_en` high, `load_bank` 0 writes the even bank and 1 writes the odd bank. State index i is loaded into bank i mod 2 at address i/2. A `load_en` pulse while generation runs has no effect on any later output.
- R7: A start pulse while generation runs is ignored: the output sequence continues unchanged.
- R8: The sequence stays correct across the bank address wrap from 77 to 0. It also stays correct where the far index passes 155, in which case the far operand is a word generated earlier in the same run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Write `load_data` into the selected bank (idle only) |
| load_bank | input | 1 | Bank select: 0 even indices, 1 odd indices |
| load_addr | input | $clog2(N_WORDS/2) | Word address inside the bank (index / 2) |
| load_data | input | 128 | State word to load |
| start | input | 1 | Begin generation from the loaded state |
| y0 | output | 128 | Earlier output word of the cycle |
| y1 | output | 128 | Later output word of the cycle |
| valid | output | 1 | `y0`/`y1` hold fresh words |

## Verification
The bench uses the default geometry of 156 words with far offset 108 and shift 3. It supplies its own mask, which clears bits in every 32-bit word, so the AND term actually shapes the result. With these values, a run of 200 cycles passes the point where the far index wraps (cycle 24) and the bank address wrap (cycle 78), and continues through a second lap. A sparse state puts single bits through the word reordering and the 64-bit shifts. An all-ones state saturates the mask term. A start pulse and a load during a run probe the ignore rules.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int unsigned WORD_W = 128;
  localparam int unsigned SUB_W  = 32;
  localparam int unsigned HALF_W = 64;

  // Reorder 32-bit words: result (msw first) = {v0, v3, v2, v1}
  function automatic logic [WORD_W-1:0] rot_cur(input logic [WORD_W-1:0] v);
    return {v[SUB_W*0 +: SUB_W], v[SUB_W*3 +: SUB_W],
            v[SUB_W*2 +: SUB_W], v[SUB_W*1 +: SUB_W]};
  endfunction

  // Reorder to {v2, v0, v3, v1} and xor with a per-64-bit left shift
  function automatic logic [WORD_W-1:0] mix_far(input logic [WORD_W-1:0] v,
                                                input int unsigned sh);
    logic [WORD_W-1:0] reord;
    logic [WORD_W-1:0] shl;
    reord = {v[SUB_W*2 +: SUB_W], v[SUB_W*0 +: SUB_W],
             v[SUB_W*3 +: SUB_W], v[SUB_W*1 +: SUB_W]};
    shl   = {v[HALF_W +: HALF_W] << sh, v[0 +: HALF_W] << sh};
    return reord ^ shl;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
// One storage bank: single write port, two combinational read ports.
module ilv_bank #(
  parameter int unsigned DEPTH = 78,
  parameter int unsigned W     = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_cur_addr,
  output logic [W-1:0]  rd_cur_data,
  input  logic [AW-1:0] rd_far_addr,
  output logic [W-1:0]  rd_far_data
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_cur_data = mem_q[rd_cur_addr];
  assign rd_far_data = mem_q[rd_far_addr];

endmodule

// File: rtl/ilv_step.sv
// One recurrence step (R4): (prev & MASK) ^ mix_far(far) ^ rot_cur(cur)
module ilv_step
  import ilv_pkg::*;
#(
  parameter int unsigned       SHIFT = 3,
  parameter logic [WORD_W-1:0] MASK  = '1
) (
  input  logic [WORD_W-1:0] prev_i,
  input  logic [WORD_W-1:0] far_i,
  input  logic [WORD_W-1:0] cur_i,
  output logic [WORD_W-1:0] next_o
);

  logic [WORD_W-1:0] masked;
  logic [WORD_W-1:0] far_term;
  logic [WORD_W-1:0] cur_term;

  always_comb begin
    masked   = prev_i & MASK;
    far_term = mix_far(far_i, SHIFT);
    cur_term = rot_cur(cur_i);
    next_o   = masked ^ far_term ^ cur_term;
  end

endmodule

// File: rtl/ilv_ptr.sv
// Bank address pointer: current slot and far slot (current + OFS mod DEPTH).
module ilv_ptr #(
  parameter int unsigned DEPTH = 78,
  parameter int unsigned OFS   = 54,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] far_o
);

  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [AW-1:0] SPLIT = AW'(DEPTH - OFS);
  localparam logic [AW-1:0] FWD   = AW'(OFS);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (adv) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign cur_o = ptr_q;
  assign far_o = (ptr_q >= SPLIT) ? (ptr_q - SPLIT) : (ptr_q + FWD);

endmodule

// File: rtl/ilv_rec_gen.sv
// Two-lane interleaved recurrence generator (top).
module ilv_rec_gen
  import ilv_pkg::*;
#(
  parameter int unsigned       N_WORDS = 156,
  parameter int unsigned       FAR_OFS = 108,
  parameter int unsigned       SHIFT   = 3,
  parameter logic [WORD_W-1:0] MASK    = 128'hdfffffef_ffbffffd_f7fffbff_fffeffdf
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_en,
  input  logic                             load_bank,
  input  logic [$clog2(N_WORDS/2)-1:0]     load_addr,
  input  logic [WORD_W-1:0]                load_data,
  input  logic                             start,
  output logic [WORD_W-1:0]                y0,
  output logic [WORD_W-1:0]                y1,
  output logic                             valid
);

  localparam int unsigned LANES = 2;
  localparam int unsigned HALF  = N_WORDS / LANES;
  localparam int unsigned FAR_H = FAR_OFS / LANES;
  localparam int unsigned AW    = $clog2(HALF);
  localparam logic [AW-1:0] LAST_ADDR = AW'(HALF - 1);

  // ---------------- reset: async assert, sync release ----------------
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  // ---------------- control state ----------------
  logic              running_q, running_d;
  logic              valid_q, valid_d;
  logic [WORD_W-1:0] prev_q, prev_d;
  logic [WORD_W-1:0] y0_q, y0_d;
  logic [WORD_W-1:0] y1_q, y1_d;

  logic start_go;
  logic load_we;
  logic gen_we;

  assign start_go = start & ~running_q;   // R7: start ignored while running
  assign load_we  = load_en & ~running_q; // R6: load ignored while running
  assign gen_we   = running_q;

  // ---------------- address pointer ----------------
  logic [AW-1:0] ptr_cur;
  logic [AW-1:0] ptr_far;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] wr_addr;

  ilv_ptr #(
    .DEPTH (HALF),
    .OFS   (FAR_H)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (start_go),
    .adv   (running_q),
    .cur_o (ptr_cur),
    .far_o (ptr_far)
  );

  // While idle the current port looks at the last slot so that the odd
  // bank presents state word N_WORDS-1 for capture into prev at start.
  assign cur_addr = running_q ? ptr_cur : LAST_ADDR;
  assign wr_addr  = running_q ? ptr_cur : load_addr;

  // ---------------- banks and chained step units ----------------
  logic [LANES-1:0][WORD_W-1:0] rd_cur;
  logic [LANES-1:0][WORD_W-1:0] rd_far;
  logic [LANES-1:0][WORD_W-1:0] y_new;
  logic [LANES-1:0][WORD_W-1:0] wr_data;
  logic [LANES-1:0]             wr_en;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [WORD_W-1:0] lane_prev;

    if (b == 0) begin : g_head
      assign lane_prev = prev_q;
    end else begin : g_chain
      assign lane_prev = y_new[b-1];
    end

    assign wr_en[b]   = gen_we | (load_we & (load_bank == 1'(b)));
    assign wr_data[b] = running_q ? y_new[b] : load_data;

    ilv_bank #(
      .DEPTH (HALF),
      .W     (WORD_W)
    ) u_bank (
      .clk         (clk),
      .wr_en       (wr_en[b]),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data[b]),
      .rd_cur_addr (cur_addr),
      .rd_cur_data (rd_cur[b]),
      .rd_far_addr (ptr_far),
      .rd_far_data (rd_far[b])
    );

    ilv_step #(
      .SHIFT (SHIFT),
      .MASK  (MASK)
    ) u_step (
      .prev_i (lane_prev),
      .far_i  (rd_far[b]),
      .cur_i  (rd_cur[b]),
      .next_o (y_new[b])
    );
  end

  // ---------------- next state ----------------
  always_comb begin
    running_d = running_q;
    prev_d    = prev_q;
    y0_d      = y0_q;
    y1_d      = y1_q;
    valid_d   = running_q;
    if (start_go) begin
      running_d = 1'b1;
      prev_d    = rd_cur[LANES-1];
    end
    if (running_q) begin
      prev_d = y_new[LANES-1];
      y0_d   = y_new[0];
      y1_d   = y_new[LANES-1];
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      running_q <= 1'b0;
      valid_q   <= 1'b0;
      prev_q    <= '0;
      y0_q      <= '0;
      y1_q      <= '0;
    end else begin
      running_q <= running_d;
      valid_q   <= valid_d;
      prev_q    <= prev_d;
      y0_q      <= y0_d;
      y1_q      <= y1_d;
    end
  end

  assign y0    = y0_q;
  assign y1    = y1_q;
  assign valid = valid_q;

endmodule

// File: rtl/ilv_rec_gen_chk.sv
module ilv_rec_gen_chk #(
  parameter int unsigned HALF = 78,
  localparam int unsigned AW  = $clog2(HALF)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          running,
  input logic          valid,
  input logic [AW-1:0] ptr,
  input logic [127:0]  prev,
  input logic [127:0]  y1
);

  localparam logic [AW-1:0] LAST = AW'(HALF - 1);

  // R2: once valid, stays valid until reset
  p_valid_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

  // R2/R1: valid only ever rises two edges after an accepted start
  p_valid_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(start, 2));

  // R2: start accepted while idle yields valid at the second edge
  p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |-> ##2 valid);

  // R7: accepted start restarts the bank pointer at slot 0
  p_start_clears_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> (ptr == '0));

  // R8: pointer advances by one each running cycle and wraps at the last slot
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |->
      (ptr == (($past(ptr) == LAST) ? AW'(0) : AW'($past(ptr) + AW'(1)))));

  // R3: the carried-over previous word is the last presented y1
  p_prev_is_y1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (prev == y1));

endmodule

bind ilv_rec_gen ilv_rec_gen_chk #(
  .HALF (N_WORDS / 2)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .start   (start),
  .running (running_q),
  .valid   (valid),
  .ptr     (ptr_cur),
  .prev    (prev_q),
  .y1      (y1)
);

// File: tb/tb_ilv_rec_gen.sv
module tb_ilv_rec_gen;

  localparam int NW   = 156;
  localparam int FAR  = 108;
  localparam int SH   = 3;
  localparam int HALF = NW / 2;
  localparam int AW   = $clog2(HALF);
  localparam logic [127:0] TB_MASK = 128'hfff7ffbf_ef7ffffe_bffdffff_fdfffbff;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en;
  logic          load_bank;
  logic [AW-1:0] load_addr;
  logic [127:0]  load_data;
  logic          start;
  logic [127:0]  y0, y1;
  logic          valid;

  always #2 clk = ~clk;

  ilv_rec_gen #(
    .N_WORDS (NW),
    .FAR_OFS (FAR),
    .SHIFT   (SH),
    .MASK    (TB_MASK)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_bank (load_bank),
    .load_addr (load_addr),
    .load_data (load_data),
    .start     (start),
    .y0        (y0),
    .y1        (y1),
    .valid     (valid)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // ---------------- single-lane reference model ----------------
  logic [127:0] ref_st [NW];
  int           ref_j;
  logic [127:0] exp_q [$];
  int           words_seen;
  string        cur_req;
  bit           seen_valid;

  function automatic logic [127:0] m_perm(input logic [127:0] x,
                                          input int a, input int b,
                                          input int c, input int d);
    logic [31:0] w [4];
    for (int i = 0; i < 4; i++) w[i] = x[32*i +: 32];
    return {w[a], w[b], w[c], w[d]};
  endfunction

  function automatic logic [127:0] m_sh64(input logic [127:0] x);
    logic [127:0] r;
    for (int h = 0; h < 2; h++) r[64*h +: 64] = x[64*h +: 64] << SH;
    return r;
  endfunction

  function automatic logic [127:0] ref_next();
    logic [127:0] pv, fr, cu, nw;
    pv = ref_st[(ref_j + NW - 1) % NW];
    fr = ref_st[(ref_j + FAR) % NW];
    cu = ref_st[ref_j];
    nw = (pv & TB_MASK) ^ m_perm(fr, 2, 0, 3, 1) ^ m_sh64(fr) ^ m_perm(cu, 0, 3, 2, 1);
    ref_st[ref_j] = nw;
    ref_j = (ref_j + 1) % NW;
    return nw;
  endfunction

  function automatic logic [127:0] pattern(input int p, input int i);
    logic [127:0] v;
    v = '0;
    case (p)
      1: for (int k = 0; k < 4; k++)
           v[32*k +: 32] = 32'(i * 32'h9e3779b9) ^ 32'(k * 32'h7f4a7c15) ^ 32'h1234_5678;
      2: begin
           if (i == NW - 1) v = 128'h80000001_00000000_00000000_00000003;
           if (i == 0)      v = 128'h00000004_00000000_00000000_80000000;
           if (i == FAR)    v = 128'h00000000_00100000_00000000_00000001;
         end
      default: v = '1;
    endcase
    return v;
  endfunction

  // ---------------- checks ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected words as the design presents them
  always @(negedge clk) begin
    if (rst_n) begin
      if (seen_valid && !valid)
        chk(1'b0, "R2", "valid dropped during run", 128'(valid), 128'd1);
      if (valid) begin
        seen_valid = 1'b1;
        if (exp_q.size() >= 2) begin
          logic [127:0] e0, e1;
          string tag;
          e0  = exp_q.pop_front();
          e1  = exp_q.pop_front();
          tag = (words_seen < 2) ? "R5" : cur_req;
          chk(y0 === e0, tag, $sformatf("y0 word %0d", words_seen), y0, e0);
          chk(y1 === e1, tag, $sformatf("y1 word %0d", words_seen + 1), y1, e1);
          words_seen += 2;
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    load_en   = 1'b0;
    load_bank = 1'b0;
    load_addr = '0;
    load_data = '0;
    start     = 1'b0;
    seen_valid = 1'b0;
    words_seen = 0;
    exp_q.delete();
    repeat (3) tick();
    chk(valid == 1'b0, "R1", "valid during reset", 128'(valid), 128'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(valid == 1'b0, "R1", "valid after reset release", 128'(valid), 128'd0);
  endtask

  // R6: index i -> bank i%2, address i/2
  task automatic load_state(input int p);
    for (int i = 0; i < NW; i++) begin
      ref_st[i] = pattern(p, i);
      load_en   = 1'b1;
      load_bank = 1'(i % 2);
      load_addr = AW'(i / 2);
      load_data = ref_st[i];
      tick();
    end
    load_en = 1'b0;
    ref_j   = 0;
    repeat (2) tick();
    chk(valid == 1'b0, "R1", "valid idle before start", 128'(valid), 128'd0);
  endtask

  task automatic run(input int n_words, input bit poke, input string req);
    int c;
    cur_req = req;
    for (int i = 0; i < n_words; i++) exp_q.push_back(ref_next());
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(valid == 1'b0, "R2", "valid one edge after start", 128'(valid), 128'd0);
    tick();
    chk(valid == 1'b1, "R2", "valid two edges after start", 128'(valid), 128'd1);
    c = 1;
    while (exp_q.size() > 0 && c < 4000) begin
      if (poke && c == 30) begin
        cur_req = "R7";           // start while running must be ignored
        start = 1'b1;
        tick();
        start = 1'b0;
        c++;
      end else if (poke && c == 60) begin
        cur_req = "R6/R8";        // load while running must be ignored
        for (int b = 0; b < 2; b++) begin
          load_en   = 1'b1;
          load_bank = 1'(b);
          load_addr = AW'(5);
          load_data = 128'hdead_beef_0bad_f00d_cafe_babe_5555_aaaa;
          tick();
          c++;
        end
        load_en = 1'b0;
      end else begin
        tick();
        c++;
      end
    end
    tick();
    chk(words_seen == n_words, "R3", "word count", 128'(words_seen), 128'(n_words));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    cur_req = "R3";
    // Pattern 1: dense state, 200 cycles (both wraps), mid-run start/load (R3 R6 R7 R8)
    do_reset();
    load_state(1);
    run(400, 1'b1, "R3");
    // Pattern 2: sparse bits to expose word order and shift direction (R4)
    do_reset();
    load_state(2);
    run(200, 1'b0, "R4");
    // Pattern 3: all ones state, mask term saturated (R4, R8)
    do_reset();
    load_state(3);
    run(170, 1'b0, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule